// File: doc/BRIEF.md
# Oversampled serial receiver with forced-parity checking

This block turns an asynchronous serial line back into characters. A 16x baud-rate enable drives it. The line format is set by five configuration inputs, the same ones the matching transmitter uses: data length (5 to 8 bits), one or two stop bits, parity on or off, even/odd select, and a forced ("sticky") parity mode. In forced mode the received parity bit is not compared with a computed parity. It is compared with the complement of the even/odd select. A master can then mark address characters apart from data characters and steer several receivers on one line.

A controller FSM has the states IDLE, START, DATA, PARITY, STOP1 and STOP2. Its transitions are:

- IDLE to START: a low sample arrives after the line has been seen high.
- START to IDLE: the start bit is not confirmed (line high at the 8th sub-bit sample).
- START to DATA: the start bit is confirmed (line low at the 8th sub-bit sample).
- DATA to DATA: one data bit is sampled and more remain.
- DATA to PARITY: the last data bit is sampled and parity is on.
- DATA to STOP1: the last data bit is sampled and parity is off.
- PARITY to STOP1: the parity bit is sampled.
- STOP1 to IDLE: the stop bit is sampled and one stop bit is set.
- STOP1 to STOP2: the stop bit is sampled and two stop bits are set.
- STOP2 to IDLE: the second stop bit is sampled.

Each finished frame gives a one-cycle valid strobe with the character. The parity-error and framing-error flags are updated in that same cycle.

The error flags are sticky until a clear strobe. They drive an interrupt request when line-status interrupts are enabled.

Top module: `uart_sticky_rx`

## Requirements
- R1: `word_len` selects the data length: 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. Bits are received LSB first. Bits of `rx_data` above the configured length read 0.
- R2: A high-to-low transition is taken as a start bit only if the line is still low at the 8th baud-enable sample counted from detection. Otherwise the receiver returns to IDLE and delivers nothing.
- R3: Each later bit is sampled 16 baud-enables after the previous sample. `rx_valid` is a single-cycle pulse that comes before the end of the final stop bit.
- R4: With parity on and forced mode off, `even_sel`=1 checks even parity and `even_sel`=0 checks odd parity. The check counts the configured data bits plus the parity bit. A mismatch sets `parity_err`.
- R5: With parity on and forced mode on, the received parity bit must equal the inverse of `even_sel`. For example, with `even_sel`=0 a received 0 sets `parity_err`.
- R6: With parity off, `sticky` has no effect. No parity bit is expected: the stop bit directly follows the data, and `parity_err` is not set.
- R7: A stop bit sampled as 0 sets `frame_err`. With two stop bits, either one being 0 sets it. The character is still delivered with `rx_valid`.
- R8: The error flags stay set until `lsr_clr` is high at a clock edge. If a new error arrives at the same edge as the clear, the flag ends up set.
- R9: `irq` is high exactly when `lsi_en` is 1 and at least one error flag is set.
- R10: After reset, `rx_valid`, `rx_data`, both flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | 16x oversampling enable, one cycle wide |
| rxd | input | 1 | Serial input line, idles high |
| word_len | input | 2 | Data length code (5 + code bits) |
| two_stop | input | 1 | 1 = two stop bits |
| par_en | input | 1 | Parity bit present and checked |
| even_sel | input | 1 | Even (1) or odd (0) parity select |
| sticky | input | 1 | Forced-parity mode |
| lsi_en | input | 1 | Line-status interrupt enable |
| lsr_clr | input | 1 | Clears the error flags |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | One-cycle strobe for a new character |
| parity_err | output | 1 | Sticky parity-error flag |
| frame_err | output | 1 | Sticky framing-error flag |
| irq | output | 1 | Line-status interrupt request |

## Verification
A flag clear and the delivery of a new erroneous character can land on the same clock edge. When that happens, the new error has to survive.

The bench provokes this case directly. It holds `lsr_clr` high through a whole frame that carries a parity error, and drops it at the first clock after `rx_valid` is seen. It then checks that `parity_err` is set in the strobe cycle and is still set after the frame.

A separate case checks that a clear with no new error drops the flags and `irq`.

// File: rtl/uart_srx_pkg.sv
package uart_srx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP1,
        RX_STOP2
    } rx_state_e;

endpackage

// File: rtl/uart_srx_sync.sv
module uart_srx_sync #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain <= {STAGES{IDLE_VAL}};
        else
            chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_srx_parity.sv
module uart_srx_parity #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2
) (
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  word_len,
    input  logic              even_sel,
    input  logic              sticky,
    input  logic              par_bit,
    output logic              mismatch
);
    localparam int MIN_LEN = DATA_W - (1 << LEN_W) + 1;

    logic [DATA_W-1:0] mask;
    logic              ones_odd;
    logic              expect_bit;

    // Bits below the shortest length are always in use; the rest depend on the code.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        if (i < MIN_LEN) begin : g_fixed
            assign mask[i] = 1'b1;
        end else begin : g_sel
            assign mask[i] = (int'(word_len) >= (i - MIN_LEN + 1));
        end
    end

    always_comb begin
        ones_odd = ^(data & mask);
        if (sticky)
            expect_bit = ~even_sel;
        else if (even_sel)
            expect_bit = ones_odd;
        else
            expect_bit = ~ones_odd;
        mismatch = (par_bit != expect_bit);
    end
endmodule

// File: rtl/uart_srx_status.sv
module uart_srx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  logic pe_evt,
    input  logic fe_evt,
    input  logic clr,
    input  logic int_en,
    output logic pe_flag,
    output logic fe_flag,
    output logic int_req
);
    // A new event at the same edge as a clear wins over the clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pe_flag <= 1'b0;
            fe_flag <= 1'b0;
        end else begin
            pe_flag <= (set_en && pe_evt) || (pe_flag && !clr);
            fe_flag <= (set_en && fe_evt) || (fe_flag && !clr);
        end
    end

    assign int_req = int_en && (pe_flag || fe_flag);
endmodule

// File: rtl/uart_sticky_rx.sv
module uart_sticky_rx
    import uart_srx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int LEN_W      = 2,
    parameter int OVERSAMPLE = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              rxd,
    input  logic [LEN_W-1:0]  word_len,
    input  logic              two_stop,
    input  logic              par_en,
    input  logic              even_sel,
    input  logic              sticky,
    input  logic              lsi_en,
    input  logic              lsr_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              parity_err,
    output logic              frame_err,
    output logic              irq
);
    localparam int CNT_W      = $clog2(OVERSAMPLE);
    localparam int IDX_W      = $clog2(DATA_W);
    localparam int MIN_LEN    = DATA_W - (1 << LEN_W) + 1;
    localparam int START_LAST = OVERSAMPLE / 2 - 2;
    localparam int BIT_LAST   = OVERSAMPLE - 1;

    rx_state_e         state, state_nx;
    logic              rxd_s;
    logic [CNT_W-1:0]  tick_cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [IDX_W-1:0]  last_idx;
    logic [DATA_W-1:0] data_q;
    logic              armed;
    logic              par_bad;
    logic              stop_bad;
    logic              samp;
    logic              detect;
    logic              deliver;
    logic              mismatch;
    logic              pe_evt;
    logic              fe_evt;

    uart_srx_sync #(
        .STAGES   (SYNC_DEPTH),
        .IDLE_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rxd_s)
    );

    uart_srx_parity #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_par (
        .data     (data_q),
        .word_len (word_len),
        .even_sel (even_sel),
        .sticky   (sticky),
        .par_bit  (rxd_s),
        .mismatch (mismatch)
    );

    // Sample events
    always_comb begin
        last_idx = IDX_W'(MIN_LEN - 1) + IDX_W'(word_len);
        detect   = baud_tick && (state == RX_IDLE) && armed && !rxd_s;
        if (state == RX_START)
            samp = baud_tick && (tick_cnt == CNT_W'(START_LAST));
        else if (state == RX_IDLE)
            samp = 1'b0;
        else
            samp = baud_tick && (tick_cnt == CNT_W'(BIT_LAST));
        deliver = samp && (((state == RX_STOP1) && !two_stop) || (state == RX_STOP2));
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= RX_IDLE;
        else
            state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:   if (detect) state_nx = RX_START;
            RX_START:  if (samp) state_nx = rxd_s ? RX_IDLE : RX_DATA;
            RX_DATA:   if (samp && (bit_idx == last_idx))
                           state_nx = par_en ? RX_PARITY : RX_STOP1;
            RX_PARITY: if (samp) state_nx = RX_STOP1;
            RX_STOP1:  if (samp) state_nx = two_stop ? RX_STOP2 : RX_IDLE;
            RX_STOP2:  if (samp) state_nx = RX_IDLE;
            default:   state_nx = RX_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            bit_idx  <= '0;
            data_q   <= '0;
            armed    <= 1'b0;
            par_bad  <= 1'b0;
            stop_bad <= 1'b0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= deliver;
            if (deliver)
                rx_data <= data_q;
            if (baud_tick) begin
                if (samp || (state == RX_IDLE))
                    tick_cnt <= '0;
                else
                    tick_cnt <= tick_cnt + 1'b1;
            end
            unique case (state)
                RX_IDLE: begin
                    if (baud_tick && rxd_s)
                        armed <= 1'b1;
                    if (detect) begin
                        armed    <= 1'b0;
                        data_q   <= '0;
                        par_bad  <= 1'b0;
                        stop_bad <= 1'b0;
                        bit_idx  <= '0;
                    end
                end
                RX_START: ;
                RX_DATA: if (samp) begin
                    data_q[bit_idx] <= rxd_s;
                    bit_idx         <= bit_idx + 1'b1;
                end
                RX_PARITY: if (samp) par_bad  <= mismatch;
                RX_STOP1:  if (samp) stop_bad <= !rxd_s;
                RX_STOP2:  ;
                default:   ;
            endcase
        end
    end

    assign pe_evt = par_en && par_bad;
    assign fe_evt = stop_bad || !rxd_s;

    uart_srx_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (deliver),
        .pe_evt  (pe_evt),
        .fe_evt  (fe_evt),
        .clr     (lsr_clr),
        .int_en  (lsi_en),
        .pe_flag (parity_err),
        .fe_flag (frame_err),
        .int_req (irq)
    );
endmodule

// File: rtl/uart_sticky_rx_chk.sv
module uart_sticky_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] word_len,
    input logic       par_en,
    input logic       lsi_en,
    input logic       lsr_clr,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic       parity_err,
    input logic       frame_err,
    input logic       irq
);
    // R3: strobe is one cycle wide
    a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R1: five-bit characters have zero upper bits
    a_r1_short_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && word_len == 2'd0) |-> (rx_data[7:5] == 3'b000));

    // R6: no parity error from a frame without parity
    a_r6_no_pe_without_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !par_en) |-> !$rose(parity_err));

    // R7: framing error appears only with a delivered character
    a_r7_fe_with_char: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> rx_valid);

    // R8: flags hold while no clear is given
    a_r8_pe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_err && !lsr_clr) |=> parity_err);
    a_r8_fe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !lsr_clr) |=> frame_err);

    // R8: a clear drops the flags unless a new character arrives
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_clr |=> ((!parity_err && !frame_err) || rx_valid));

    // R9: interrupt only with enable and a flag
    a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (lsi_en && (parity_err || frame_err)));
    a_r9_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (lsi_en && (parity_err || frame_err)) |-> irq);
endmodule

bind uart_sticky_rx uart_sticky_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_len   (word_len),
    .par_en     (par_en),
    .lsi_en     (lsi_en),
    .lsr_clr    (lsr_clr),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .parity_err (parity_err),
    .frame_err  (frame_err),
    .irq        (irq)
);

// File: tb/tb_uart_sticky_rx.sv
module tb_uart_sticky_rx;
    localparam int TICK_DIV = 2;
    localparam int OVS      = 16;
    localparam int NVEC     = 12;

    typedef struct packed {
        logic [1:0] wl;
        logic       s2;
        logic       pen;
        logic       evn;
        logic       stk;
        logic       lsi;
        logic [7:0] d;
        logic       flip;
        logic       bst;
    } vec_t;

    // wl, two-stop, parity, even, sticky, irq-en, data, flip parity, bad stop
    localparam vec_t VEC [NVEC] = '{
        '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0},
        '{2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h2B, 1'b0, 1'b0},
        '{2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h55, 1'b1, 1'b0},
        '{2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h01, 1'b0, 1'b0},
        '{2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h80, 1'b1, 1'b0},
        '{2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b0},
        '{2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'hC3, 1'b0, 1'b0},
        '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b1},
        '{2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h7E, 1'b0, 1'b1},
        '{2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h96, 1'b1, 1'b0},
        '{2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h13, 1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] word_len = 2'd3;
    logic       two_stop = 1'b0;
    logic       par_en = 1'b0;
    logic       even_sel = 1'b0;
    logic       sticky = 1'b0;
    logic       lsi_en = 1'b0;
    logic       lsr_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       parity_err;
    logic       frame_err;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int seen = 0;
    logic [7:0] cap_d = '0;
    logic cap_pe = 1'b0;
    logic cap_fe = 1'b0;
    logic drop_clr = 1'b0;
    int div_cnt = 0;

    uart_sticky_rx dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .rxd        (rxd),
        .word_len   (word_len),
        .two_stop   (two_stop),
        .par_en     (par_en),
        .even_sel   (even_sel),
        .sticky     (sticky),
        .lsi_en     (lsi_en),
        .lsr_clr    (lsr_clr),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .parity_err (parity_err),
        .frame_err  (frame_err),
        .irq        (irq)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        div_cnt   <= (div_cnt == TICK_DIV - 1) ? 0 : div_cnt + 1;
        baud_tick <= (div_cnt == TICK_DIV - 1);
    end

    always @(negedge clk) begin
        if (rx_valid) begin
            seen   = seen + 1;
            cap_d  = rx_data;
            cap_pe = parity_err;
            cap_fe = frame_err;
            if (drop_clr) begin
                lsr_clr  = 1'b0;
                drop_clr = 1'b0;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (OVS * TICK_DIV) @(negedge clk);
    endtask

    function automatic logic par_bit(input vec_t v);
        logic [7:0] m;
        logic p;
        m = 8'hFF >> (3 - v.wl);
        if (v.stk) p = ~v.evn;
        else if (v.evn) p = ^(v.d & m);
        else p = ~(^(v.d & m));
        return p ^ v.flip;
    endfunction

    task automatic send(input vec_t v);
        seen = 0;
        drive_bit(1'b0);
        for (int i = 0; i < 5 + int'(v.wl); i++) drive_bit(v.d[i]);
        if (v.pen) drive_bit(par_bit(v));
        drive_bit(!v.bst);
        if (v.s2) drive_bit(1'b1);
    endtask

    task automatic setup(input vec_t v);
        word_len = v.wl;
        two_stop = v.s2;
        par_en   = v.pen;
        even_sel = v.evn;
        sticky   = v.stk;
        lsi_en   = v.lsi;
    endtask

    task automatic clear_flags();
        lsr_clr = 1'b1;
        @(negedge clk);
        lsr_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        check("R10", "rx_valid", rx_valid, 0);
        check("R10", "rx_data", rx_data, 0);
        check("R10", "parity_err", parity_err, 0);
        check("R10", "frame_err", frame_err, 0);
        check("R10", "irq", irq, 0);
        rst_n = 1'b1;
        repeat (OVS * TICK_DIV) @(negedge clk);

        for (int k = 0; k < NVEC; k++) begin
            vec_t v;
            logic [7:0] m;
            string ptag;
            v = VEC[k];
            m = 8'hFF >> (3 - v.wl);
            ptag = v.pen ? (v.stk ? "R5" : "R4") : "R6";
            setup(v);
            send(v);
            // R3: exactly one strobe, before the last stop bit ended
            check("R3", "strobe count", seen, 1);
            // R1: data with upper bits zero
            check("R1", "rx_data", cap_d, v.d & m);
            check(ptag, "parity_err", cap_pe, v.pen & v.flip);
            // R7: framing error with character delivered
            check("R7", "frame_err", cap_fe, v.bst);
            drive_bit(1'b1);
            // R9: interrupt gating
            check("R9", "irq", irq, v.lsi & ((v.pen & v.flip) | v.bst));
            // R8: clear drops flags
            clear_flags();
            check("R8", "flags after clear", {parity_err, frame_err, irq}, 0);
        end

        // R2: short low glitch is not a start bit
        setup(VEC[0]);
        seen = 0;
        rxd = 1'b0;
        repeat (5 * TICK_DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (14 * OVS * TICK_DIV) @(negedge clk);
        check("R2", "strobes after glitch", seen, 0);
        send(VEC[0]);
        check("R2", "frame after glitch count", seen, 1);
        check("R2", "frame after glitch data", cap_d, 8'hA5);
        drive_bit(1'b1);

        // R8: new parity error at the same edge as a clear keeps the flag
        begin
            vec_t v;
            v = '{2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h0F, 1'b1, 1'b0};
            setup(v);
            lsr_clr  = 1'b1;
            drop_clr = 1'b1;
            send(v);
            check("R8", "pe at strobe under clear", cap_pe, 1);
            drive_bit(1'b1);
            check("R8", "pe kept after clear", parity_err, 1);
            check("R9", "irq after kept flag", irq, 1);
            clear_flags();
            check("R8", "pe cleared later", parity_err, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule